// File: doc/BRIEF.md
# Unaligned Load/Store Splitter

This block sits between a load/store requester and a byte-addressable RAM port that only accepts naturally aligned accesses. A request of 1, 2, 4 or 8 bytes at any byte address is broken into aligned sub-accesses by repeated halving. An access that is misaligned for its size becomes two accesses of half the size, at the address and at the address plus half the size. Each half is split the same way while it is still misaligned. Because both halves of a split share the same low-order misalignment, every leaf of one request ends up with the same size. The block therefore works out that leaf size once and walks the leaves in ascending address order.

For loads, the block places the bytes returned by each sub-access at their little-endian position in the result. For stores, it sends each sub-access the matching slice of the write data. Before each sub-access is issued, its byte span is checked against the RAM size. The first sub-access that would reach past the end of RAM is not sent, the request stops there, and the single response carries an access-fault flag.

Top module: `unaligned_splitter`

## Requirements
- R1: A request whose address is a multiple of its size is issued as exactly one downstream access, with the same address and the same size code.
- R2: Otherwise the leaf size is found by halving. Starting from the request size, the size is halved while the address is not a multiple of it. The request is issued as leaves of that size at A, A+L, A+2L, and so on, covering the request bytes. A is the request address and L is the leaf size. Leaves are issued in ascending order, and each address is formed by wrapping addition over ADDR_W bits.
- R3: Data is little-endian. Bytes [k*L, k*L+L) of the request data belong to leaf k. On a store they are driven right-justified on mem_wdata_o. On a load they are taken right-justified from mem_rdata_i and placed at that position in rsp_rdata_o.
- R4: Size codes on req_size_i and mem_size_o are 0=1, 1=2, 2=4 and 3=8 bytes. Load result bytes at or above the request size are zero. rsp_rdata_o is zero for a store.
- R5: A leaf is out of range when its address plus L exceeds RAM_BYTES. Such a leaf is never issued, and no later leaf of that request is issued. The response has rsp_fault_o=1, and leaves written before the fault keep their data. A request with no out-of-range leaf responds with rsp_fault_o=0.
- R6: req_ready_o is high only when the block is idle. It goes low in the cycle after a request is accepted and stays low until the response. Each request produces exactly one single-cycle rsp_valid_o pulse, with ready high again in the following cycle.
- R7: At most one downstream access is outstanding. mem_en_o is never high in two consecutive cycles, and read data is expected on mem_rdata_i in the cycle after mem_en_o. After reset, req_ready_o=1, mem_en_o=0 and rsp_valid_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high together with valid |
| req_addr_i | input | ADDR_W | Request byte address |
| req_size_i | input | 2 | Request size code (0..3 = 1..8 bytes) |
| req_write_i | input | 1 | 1 = store, 0 = load |
| req_wdata_i | input | 64 | Store data, right-justified |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_rdata_o | output | 64 | Load result, zero-extended |
| rsp_fault_o | output | 1 | Access fault for the whole request |
| mem_en_o | output | 1 | Downstream access strobe |
| mem_we_o | output | 1 | Downstream write enable |
| mem_addr_o | output | ADDR_W | Downstream aligned address |
| mem_size_o | output | 2 | Downstream size code |
| mem_wdata_o | output | 64 | Downstream write data, right-justified |
| mem_rdata_i | input | 64 | Downstream read data, one cycle after mem_en_o |

## Verification
Several properties are checked on every cycle by the assertions: each downstream access is aligned to its own size and lies inside RAM, no two strobes are back to back, ready drops after an accept, and a response is a single pulse that returns the block to idle. Other behaviour only the directed scenarios can show. This covers the exact leaf sequence chosen for each address and size, the little-endian placement of bytes in loads and stores, and zero-filling of unused result bytes. It also covers where a request stops at the RAM boundary, and that bytes written before a fault remain while bytes after it are untouched.

// File: rtl/split_pkg.sv
package split_pkg;
  localparam int DATA_BYTES = 8;
  localparam int DATA_W     = DATA_BYTES * 8;
  localparam int SIZE_W     = $clog2($clog2(DATA_BYTES) + 1);
  localparam int IDX_W      = $clog2(DATA_BYTES);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_RESP
  } seq_st_e;

  // halve the size while the address is misaligned for it
  function automatic logic [SIZE_W-1:0] leaf_lg(input logic [IDX_W-1:0] lo,
                                                input logic [SIZE_W-1:0] sz);
    logic [SIZE_W-1:0] lg;
    lg = sz;
    for (int i = IDX_W; i > 0; i--) begin
      if (lg == SIZE_W'(i) && (lo & IDX_W'((1 << i) - 1)) != '0) lg = SIZE_W'(i - 1);
    end
    return lg;
  endfunction
endpackage

// File: rtl/split_plan.sv
module split_plan
  import split_pkg::*;
(
  input  logic [IDX_W-1:0]  addr_lo_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic [SIZE_W-1:0] leaf_lg_o,
  output logic [IDX_W-1:0]  last_o
);
  logic [SIZE_W-1:0] depth;

  always_comb begin
    leaf_lg_o = leaf_lg(addr_lo_i, size_i);
    depth     = size_i - leaf_lg_o;
    last_o    = IDX_W'((1 << depth) - 1);
  end
endmodule

// File: rtl/split_seq.sv
module split_seq
  import split_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int RAM_BYTES = 4096
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_write_i,
  input  logic [SIZE_W-1:0] leaf_lg_i,
  input  logic [IDX_W-1:0]  last_i,
  output logic              req_ready_o,
  output logic              accept_o,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [SIZE_W-1:0] mem_size_o,
  output logic              cap_o,
  output logic [IDX_W-1:0]  k_o,
  output logic              rsp_valid_o,
  output logic              rsp_fault_o
);
  localparam logic [ADDR_W:0] RAM_END = (ADDR_W+1)'(RAM_BYTES);

  seq_st_e           st_q;
  logic [ADDR_W-1:0] cur_q;
  logic [IDX_W-1:0]  k_q, last_q;
  logic [SIZE_W-1:0] lg_q;
  logic              we_q, fault_q;
  logic [ADDR_W-1:0] step;
  logic [ADDR_W:0]   leaf_end;
  logic              leaf_oob;

  assign step     = ADDR_W'(1) << lg_q;
  assign leaf_end = {1'b0, cur_q} + {1'b0, step};
  assign leaf_oob = leaf_end > RAM_END;
  assign accept_o = (st_q == ST_IDLE) && req_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cur_q   <= '0;
      k_q     <= '0;
      last_q  <= '0;
      lg_q    <= '0;
      we_q    <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept_o) begin
          st_q    <= ST_ISSUE;
          cur_q   <= req_addr_i;
          k_q     <= '0;
          last_q  <= last_i;
          lg_q    <= leaf_lg_i;
          we_q    <= req_write_i;
          fault_q <= 1'b0;
        end
        ST_ISSUE: begin
          if (leaf_oob) begin
            fault_q <= 1'b1;
            st_q    <= ST_RESP;
          end else begin
            st_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (k_q == last_q) begin
            st_q <= ST_RESP;
          end else begin
            k_q   <= k_q + 1'b1;
            cur_q <= cur_q + step; // wraps over ADDR_W
            st_q  <= ST_ISSUE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (st_q == ST_IDLE);
  assign mem_en_o    = (st_q == ST_ISSUE) && !leaf_oob;
  assign mem_we_o    = we_q;
  assign mem_addr_o  = cur_q;
  assign mem_size_o  = lg_q;
  assign cap_o       = (st_q == ST_WAIT) && !we_q;
  assign k_o         = k_q;
  assign rsp_valid_o = (st_q == ST_RESP);
  assign rsp_fault_o = fault_q;
endmodule

// File: rtl/split_data.sv
module split_data
  import split_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [SIZE_W-1:0] leaf_lg_i,
  input  logic [IDX_W-1:0]  k_i,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0]  wdata_q;
  logic [IDX_W+2:0]   bit_off;
  logic [IDX_W-1:0]   byte_off;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     wdata_q <= '0;
    else if (load_i) wdata_q <= wdata_i;
  end

  assign bit_off     = {k_i, 3'b000} << leaf_lg_i;
  assign byte_off    = k_i << leaf_lg_i;
  assign mem_wdata_o = wdata_q >> bit_off;

  for (genvar j = 0; j < DATA_BYTES; j++) begin : g_lane
    localparam logic [IDX_W-1:0] J = IDX_W'(j);
    logic [7:0]       b_q;
    logic             hit;
    logic [IDX_W-1:0] src;

    assign hit = (J >> leaf_lg_i) == k_i;
    assign src = J - byte_off;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             b_q <= '0;
      else if (load_i)         b_q <= '0;
      else if (cap_i && hit)   b_q <= mem_rdata_i[{src, 3'b000} +: 8];
    end

    assign rdata_o[j*8 +: 8] = b_q;
  end
endmodule

// File: rtl/unaligned_splitter.sv
module unaligned_splitter
  import split_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int RAM_BYTES = 4096
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_size_i,
  input  logic              req_write_i,
  input  logic [63:0]       req_wdata_i,
  output logic              rsp_valid_o,
  output logic [63:0]       rsp_rdata_o,
  output logic              rsp_fault_o,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [1:0]        mem_size_o,
  output logic [63:0]       mem_wdata_o,
  input  logic [63:0]       mem_rdata_i
);
  logic [SIZE_W-1:0] leaf_lg;
  logic [IDX_W-1:0]  last_idx, k;
  logic              accept, cap;

  split_plan u_plan (
    .addr_lo_i (req_addr_i[IDX_W-1:0]),
    .size_i    (req_size_i),
    .leaf_lg_o (leaf_lg),
    .last_o    (last_idx)
  );

  split_seq #(.ADDR_W(ADDR_W), .RAM_BYTES(RAM_BYTES)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_addr_i  (req_addr_i),
    .req_write_i (req_write_i),
    .leaf_lg_i   (leaf_lg),
    .last_i      (last_idx),
    .req_ready_o (req_ready_o),
    .accept_o    (accept),
    .mem_en_o    (mem_en_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_size_o  (mem_size_o),
    .cap_o       (cap),
    .k_o         (k),
    .rsp_valid_o (rsp_valid_o),
    .rsp_fault_o (rsp_fault_o)
  );

  split_data u_data (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (accept),
    .wdata_i     (req_wdata_i),
    .leaf_lg_i   (mem_size_o),
    .k_i         (k),
    .cap_i       (cap),
    .mem_rdata_i (mem_rdata_i),
    .mem_wdata_o (mem_wdata_o),
    .rdata_o     (rsp_rdata_o)
  );
endmodule

// File: rtl/split_checker.sv
module split_checker #(
  parameter int ADDR_W    = 32,
  parameter int RAM_BYTES = 4096
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic              mem_en_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [1:0]        mem_size_o
);
  AST_LEAF_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_en_o |-> (mem_addr_o & ((ADDR_W'(1) << mem_size_o) - ADDR_W'(1))) == '0); // R2

  AST_LEAF_IN_RAM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_en_o |-> ({1'b0, mem_addr_o} + ((ADDR_W+1)'(1) << mem_size_o)) <= (ADDR_W+1)'(RAM_BYTES)); // R5

  AST_ONE_OUTSTANDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_en_o |=> !mem_en_o); // R7

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o); // R6

  AST_RSP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> (!rsp_valid_o && req_ready_o)); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!mem_en_o && !rsp_valid_o)); // R6
endmodule

bind unaligned_splitter split_checker #(.ADDR_W(ADDR_W), .RAM_BYTES(RAM_BYTES)) u_chk (.*);

// File: tb/unaligned_splitter_test.sv
`timescale 1ns/1ps
module unaligned_splitter_test;
  localparam int AW  = 16;
  localparam int RAM = 512;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_write = 1'b0;
  logic [63:0] req_wdata = '0;
  logic        req_ready, rsp_valid, rsp_fault, mem_en, mem_we;
  logic [63:0] rsp_rdata, mem_wdata;
  logic [63:0] mem_rdata = '0;
  logic [AW-1:0] mem_addr;
  logic [1:0]  mem_size;

  always #5 clk = ~clk;

  unaligned_splitter #(.ADDR_W(AW), .RAM_BYTES(RAM)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_size_i(req_size),
    .req_write_i(req_write), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .rsp_fault_o(rsp_fault),
    .mem_en_o(mem_en), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_size_o(mem_size), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  // RAM model and access trace
  logic [7:0]    ram [RAM];
  logic [7:0]    shadow [RAM];
  logic [AW-1:0] tr_addr [256];
  logic [1:0]    tr_size [256];
  int            tr_n = 0;

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        for (int i = 0; i < (1 << mem_size); i++)
          ram[(int'(mem_addr) + i) % RAM] <= mem_wdata[i*8 +: 8];
      end else begin
        for (int i = 0; i < 8; i++)
          mem_rdata[i*8 +: 8] <= ram[(int'(mem_addr) + i) % RAM];
      end
      tr_addr[tr_n % 256] <= mem_addr;
      tr_size[tr_n % 256] <= mem_size;
      tr_n <= tr_n + 1;
    end
  end

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // response of the last request
  logic [63:0] r_data;
  bit          r_fault;

  task automatic plan(input logic [AW-1:0] a, input int s,
                      output int lg, output int n_ok, output bit flt);
    int n;
    lg = s;
    while (lg > 0 && (int'(a) % (1 << lg)) != 0) lg--;
    n = 1 << (s - lg);
    n_ok = n;
    flt = 1'b0;
    for (int k = 0; k < n; k++) begin
      logic [AW-1:0] ak;
      ak = a + AW'(k << lg);
      if (int'(ak) + (1 << lg) > RAM) begin
        n_ok = k;
        flt = 1'b1;
        break;
      end
    end
  endtask

  // issue one request and check trace, handshake and fault
  task automatic run(input string tag, input logic [AW-1:0] a, input int s,
                     input bit w, input logic [63:0] wd);
    int base, cyc, lg, n_ok, cnt;
    bit got, prev_en, bad_ready, dbl, flt;
    plan(a, s, lg, n_ok, flt);
    base = tr_n;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size = 2'(s); req_write = w; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    got = 0; prev_en = 0; bad_ready = 0; dbl = 0; cyc = 0;
    while (!got && cyc < 100) begin
      if (rsp_valid) begin
        got = 1; r_data = rsp_rdata; r_fault = rsp_fault;
      end else if (req_ready) bad_ready = 1;
      if (mem_en && prev_en) dbl = 1;
      prev_en = mem_en;
      if (!got) @(negedge clk);
      cyc++;
    end
    chk(got, "R6", "response seen", 64'(got), 64'd1);
    chk(!bad_ready, "R6", "ready low while busy", 64'(bad_ready), 64'd0);
    chk(!dbl, "R7", "no back-to-back strobe", 64'(dbl), 64'd0);
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R6", "single response pulse",
        {62'd0, rsp_valid, req_ready}, 64'd1);
    cnt = tr_n - base;
    chk(cnt == n_ok, tag, "leaf count", 64'(cnt), 64'(n_ok));
    chk(r_fault == flt, "R5", "fault flag", 64'(r_fault), 64'(flt));
    if (cnt == n_ok) begin
      for (int k = 0; k < n_ok; k++) begin
        logic [AW-1:0] ea;
        ea = a + AW'(k << lg);
        chk(tr_addr[(base + k) % 256] == ea && int'(tr_size[(base + k) % 256]) == lg,
            tag, "leaf addr/size", {46'd0, tr_size[(base + k) % 256], tr_addr[(base + k) % 256]},
            {46'd0, 2'(lg), ea});
      end
    end
    if (w) begin
      for (int k = 0; k < (n_ok << lg); k++)
        shadow[(int'(a) + k) % RAM] = wd[k*8 +: 8];
    end
  endtask

  task automatic do_load(input string tag, input logic [AW-1:0] a, input int s);
    logic [63:0] exp;
    exp = '0;
    for (int j = 0; j < (1 << s); j++) exp[j*8 +: 8] = shadow[(int'(a) + j) % RAM];
    run(tag, a, s, 1'b0, 64'd0);
    if (!r_fault) chk(r_data == exp, "R3", "load data", r_data, exp);
  endtask

  task automatic do_store(input string tag, input logic [AW-1:0] a, input int s,
                          input logic [63:0] wd);
    bit same;
    run(tag, a, s, 1'b1, wd);
    chk(r_data == 64'd0, "R4", "store rdata zero", r_data, 64'd0);
    same = 1'b1;
    for (int i = 0; i < RAM; i++) if (ram[i] != shadow[i]) same = 1'b0;
    chk(same, "R3", "ram contents after store", 64'(same), 64'd1);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(req_ready == 1'b1, "R7", "reset ready", 64'(req_ready), 64'd1);
    chk(mem_en == 1'b0, "R7", "reset mem_en", 64'(mem_en), 64'd0);
    chk(rsp_valid == 1'b0, "R7", "reset rsp_valid", 64'(rsp_valid), 64'd0);
  endtask

  task automatic t_aligned;
    do_load("R1", 16'h0040, 3);
    do_load("R1", 16'h0044, 2);
    do_load("R1", 16'h0046, 1);
    do_load("R1", 16'h0047, 0);
    chk(r_data[63:8] == '0, "R4", "byte load zero upper", r_data, {56'd0, r_data[7:0]});
    do_store("R1", 16'h0048, 3, 64'hDEAD_BEEF_0123_4567);
    do_load("R1", 16'h0048, 3);
  endtask

  task automatic t_split_load;
    do_load("R2", 16'h0041, 3);
    do_load("R2", 16'h0042, 3);
    do_load("R2", 16'h0044, 3);
    do_load("R2", 16'h0013, 2);
    do_load("R2", 16'h000E, 2);
    do_load("R2", 16'h0021, 1);
    chk(r_data[63:16] == '0, "R4", "half load zero upper", r_data, {48'd0, r_data[15:0]});
  endtask

  task automatic t_split_store;
    do_store("R2", 16'h0083, 3, 64'h1122_3344_5566_7788);
    do_load("R3", 16'h0083, 3);
    do_store("R2", 16'h0095, 1, 64'h0000_0000_0000_A55A);
    do_store("R2", 16'h00A6, 2, 64'h0000_0000_CAFE_F00D);
    do_load("R3", 16'h00A4, 3);
  endtask

  task automatic t_fault;
    do_load("R5", 16'h01F8, 3);
    chk(r_fault == 1'b0, "R5", "last aligned dword no fault", 64'(r_fault), 64'd0);
    do_load("R5", 16'h01FE, 3);
    chk(r_fault == 1'b1, "R5", "dword crossing end faults", 64'(r_fault), 64'd1);
    do_store("R5", 16'h01FF, 2, 64'h0000_0000_9988_7766);
    chk(ram[511] == 8'h66, "R5", "byte before fault kept", 64'(ram[511]), 64'h66);
    do_load("R5", 16'h0300, 0);
    chk(r_fault == 1'b1, "R5", "out of range byte faults", 64'(r_fault), 64'd1);
  endtask

  initial begin
    for (int i = 0; i < RAM; i++) begin
      ram[i]    = 8'(i * 37 + 5);
      shadow[i] = 8'(i * 37 + 5);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_aligned();
    t_split_load();
    t_split_store();
    t_fault();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R6 watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule